// File: doc/BRIEF.md
# JTAG Test Access Port with Fabric User-Scan Chains

This block is a complete boundary-scan test access port clocked by the test clock. It has the sixteen-state controller, a six-bit instruction register, a one-bit bypass register and a 32-bit identification register. On top of this it provides up to four user scan chains. Each chain is tied to one instruction code. When that code is loaded, the chain gets a select flag and a gated data clock. All chains share a reset, capture/shift/update strobes and a copy of the serial input. Each chain returns its own serial output, and the block routes it to the device output pin.

Fabric logic sees only these fabric-side signals. It builds its own shift register on the gated data clock and loads or shifts it under the strobes. The test host drives the four pins in the usual way. A power-on reset input stands in for device power-up and forces the controller into its reset state.

Top module: `jtag_user_tap`

## Requirements
- R1: Five consecutive test-clock rising edges with TMS high bring the controller to Test-Logic-Reset from any state. Test-Logic-Reset loads the instruction register with the all-ones bypass code 6'h3F.
- R2: `usr_reset` is high while the controller is in Test-Logic-Reset or power-on reset is asserted. It falls on the first falling test-clock edge after the controller leaves that state.
- R3: In Capture-IR the instruction shift register loads 6'b000001. Shift-IR then presents it on `tdo` least significant bit first.
- R4: `usr_sel[k]` is high only while the latched instruction equals chain k's code (6'h02, 6'h03, 6'h22, 6'h23 for k = 0..3). It changes only on the falling test-clock edge in Update-IR or Test-Logic-Reset.
- R5: `usr_drck[k]` follows `tck` while chain k is selected and the controller is in Capture-DR or Shift-DR. At all other times it is held high. A shift of n bits therefore gives n+1 rising edges on the selected chain and none on the others.
- R6: `usr_capture`, `usr_shift` and `usr_update` are high while the controller is in Capture-DR, Shift-DR and Update-DR respectively. Each updates on the falling test-clock edge, and at most one is high at a time.
- R7: `usr_tdi` is a combinational copy of `tdi`.
- R8: While a user code is loaded and the controller is in Shift-DR, `tdo` carries that chain's `usr_tdo`, sampled on the falling test-clock edge.
- R9: The bypass code 6'h3F, and every code that is assigned to nothing, select the one-bit bypass register. This register captures 0, so an n-bit shift returns 0 followed by the first n-1 input bits.
- R10: Code 6'h09 selects the identification register. It captures the parameter `IDCODE_VAL` (bit 0 set) and shifts it out least significant bit first.
- R11: `tdo_oe` is high only for test-clock cycles spent in Shift-IR or Shift-DR. It updates on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, valid while `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| usr_sel | output | NUM_CHAINS | Per-chain select flag |
| usr_reset | output | 1 | Shared fabric reset, high in Test-Logic-Reset |
| usr_drck | output | NUM_CHAINS | Per-chain gated data clock |
| usr_capture | output | 1 | Capture-DR strobe |
| usr_shift | output | 1 | Shift-DR strobe |
| usr_update | output | 1 | Update-DR strobe |
| usr_tdi | output | 1 | Feed-through of `tdi` |
| usr_tdo | input | NUM_CHAINS | Serial return from each fabric chain |

## Verification
The hardest case to reach is Test-Logic-Reset forced from the middle of a data shift while a user chain is selected. In that case the select flag, the gated clock, the output enable and the instruction all have to drop back at once. The bench loads a user code, enters Shift-DR, and then holds TMS high for exactly five edges. It checks the fabric outputs on the falling edge that follows, then runs a bypass shift to show that the instruction really reverted. The bench also models a byte-wide fabric register on each gated clock. This exposes both the capture edge and any extra or missing clock edge in the contents and in the edge counts.

// File: rtl/jtag_user_tap_pkg.sv
package jtag_user_tap_pkg;

  localparam int IR_W = 6;
  localparam int MAX_CHAINS = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_BYPASS  = '1;
  localparam logic [IR_W-1:0] OP_IDCODE  = 6'h09;
  localparam logic [IR_W-1:0] IR_CAPTURE = 6'b000001;

  // Next-state rule of the test access port controller
  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    unique case (s)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  // Instruction code assigned to user chain idx
  function automatic logic [IR_W-1:0] user_opcode(input int unsigned idx);
    logic [IR_W-1:0] c;
    case (idx)
      0:       c = 6'h02;
      1:       c = 6'h03;
      2:       c = 6'h22;
      default: c = 6'h23;
    endcase
    return c;
  endfunction

  function automatic logic in_dr_clocked(input tap_state_e s);
    return (s == ST_CAP_DR) || (s == ST_SH_DR);
  endfunction

  function automatic logic in_shift(input tap_state_e s);
    return (s == ST_SH_DR) || (s == ST_SH_IR);
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_user_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_user_tap_pkg::*;
#(
  parameter int NUM_CHAINS = 4
) (
  input  logic                  tck,
  input  logic                  por_n,
  input  tap_state_e            state,
  input  logic                  tdi,
  output logic [IR_W-1:0]       ir_q,
  output logic                  ir_tdo_bit,
  output logic                  hit_idcode,
  output logic [NUM_CHAINS-1:0] hit_user
);

  logic [IR_W-1:0] ir_sh;

  // Capture and shift on the rising edge
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  // Latch on the falling edge; the reset state forces bypass
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)                 ir_q <= OP_BYPASS;
    else if (state == ST_TLR)   ir_q <= OP_BYPASS;
    else if (state == ST_UPD_IR) ir_q <= ir_sh;
  end

  assign ir_tdo_bit = ir_sh[0];
  assign hit_idcode = (ir_q == OP_IDCODE);

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_dec
    assign hit_user[k] = (ir_q == user_opcode(k));
  end

endmodule

// File: rtl/jtag_dr_unit.sv
module jtag_dr_unit
  import jtag_user_tap_pkg::*;
#(
  parameter int          NUM_CHAINS = 4,
  parameter logic [31:0] IDCODE_VAL = 32'h1A2B_C0DF
) (
  input  logic                  tck,
  input  logic                  por_n,
  input  tap_state_e            state,
  input  logic                  tdi,
  input  logic                  ir_tdo_bit,
  input  logic                  hit_idcode,
  input  logic [NUM_CHAINS-1:0] hit_user,
  input  logic [NUM_CHAINS-1:0] usr_tdo,
  output logic                  tdo,
  output logic                  tdo_oe
);

  localparam int ID_W = 32;

  logic            byp_q;
  logic [ID_W-1:0] id_sh;
  logic            dr_bit;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q <= 1'b0;
      id_sh <= '0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          byp_q <= 1'b0;
          id_sh <= IDCODE_VAL;
        end
        ST_SH_DR: begin
          byp_q <= tdi;
          id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  // User chains win, then identification, else bypass
  always_comb begin
    if (|hit_user)       dr_bit = |(hit_user & usr_tdo);
    else if (hit_idcode) dr_bit = id_sh[0];
    else                 dr_bit = byp_q;
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift(state);
      if (state == ST_SH_IR)      tdo <= ir_tdo_bit;
      else if (state == ST_SH_DR) tdo <= dr_bit;
    end
  end

endmodule

// File: rtl/jtag_fabric_strobes.sv
module jtag_fabric_strobes
  import jtag_user_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  tap_state_e state,
  output logic       usr_reset,
  output logic       usr_capture,
  output logic       usr_shift,
  output logic       usr_update
);

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      usr_reset   <= 1'b1;
      usr_capture <= 1'b0;
      usr_shift   <= 1'b0;
      usr_update  <= 1'b0;
    end else begin
      usr_reset   <= (state == ST_TLR);
      usr_capture <= (state == ST_CAP_DR);
      usr_shift   <= (state == ST_SH_DR);
      usr_update  <= (state == ST_UPD_DR);
    end
  end

endmodule

// File: rtl/jtag_user_port.sv
module jtag_user_port
  import jtag_user_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       sel,
  input  tap_state_e state,
  output logic       drck
);

  logic en_neg;
  logic live;

  // Opens on a falling edge; the rising-edge state term closes it while tck is high
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) en_neg <= 1'b0;
    else        en_neg <= sel && in_dr_clocked(state);
  end

  assign live = in_dr_clocked(state);
  assign drck = tck | ~(en_neg & live);

endmodule

// File: rtl/jtag_user_tap.sv
module jtag_user_tap
  import jtag_user_tap_pkg::*;
#(
  parameter int          NUM_CHAINS = 4,
  parameter logic [31:0] IDCODE_VAL = 32'h1A2B_C0DF
) (
  input  logic                  tck,
  input  logic                  por_n,
  input  logic                  tms,
  input  logic                  tdi,
  output logic                  tdo,
  output logic                  tdo_oe,
  output logic [NUM_CHAINS-1:0] usr_sel,
  output logic                  usr_reset,
  output logic [NUM_CHAINS-1:0] usr_drck,
  output logic                  usr_capture,
  output logic                  usr_shift,
  output logic                  usr_update,
  output logic                  usr_tdi,
  input  logic [NUM_CHAINS-1:0] usr_tdo
);

  tap_state_e            tap_state;
  logic [IR_W-1:0]       ir_q;
  logic                  ir_tdo_bit;
  logic                  hit_idcode;
  logic [NUM_CHAINS-1:0] hit_user;

  jtag_tap_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .state (tap_state)
  );

  jtag_ir_unit #(.NUM_CHAINS(NUM_CHAINS)) u_ir (
    .tck        (tck),
    .por_n      (por_n),
    .state      (tap_state),
    .tdi        (tdi),
    .ir_q       (ir_q),
    .ir_tdo_bit (ir_tdo_bit),
    .hit_idcode (hit_idcode),
    .hit_user   (hit_user)
  );

  jtag_dr_unit #(.NUM_CHAINS(NUM_CHAINS), .IDCODE_VAL(IDCODE_VAL)) u_dr (
    .tck        (tck),
    .por_n      (por_n),
    .state      (tap_state),
    .tdi        (tdi),
    .ir_tdo_bit (ir_tdo_bit),
    .hit_idcode (hit_idcode),
    .hit_user   (hit_user),
    .usr_tdo    (usr_tdo),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe)
  );

  jtag_fabric_strobes u_strb (
    .tck         (tck),
    .por_n       (por_n),
    .state       (tap_state),
    .usr_reset   (usr_reset),
    .usr_capture (usr_capture),
    .usr_shift   (usr_shift),
    .usr_update  (usr_update)
  );

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
    jtag_user_port u_port (
      .tck   (tck),
      .por_n (por_n),
      .sel   (hit_user[k]),
      .state (tap_state),
      .drck  (usr_drck[k])
    );
  end

  assign usr_sel = hit_user;
  assign usr_tdi = tdi;

endmodule

// File: rtl/jtag_user_tap_chk.sv
module jtag_user_tap_chk
  import jtag_user_tap_pkg::*;
#(
  parameter int NUM_CHAINS = 4
) (
  input logic                  tck,
  input logic                  por_n,
  input logic                  tms,
  input logic                  tdi,
  input logic                  tdo_oe,
  input logic [NUM_CHAINS-1:0] usr_sel,
  input logic                  usr_reset,
  input logic [NUM_CHAINS-1:0] usr_drck,
  input logic                  usr_capture,
  input logic                  usr_shift,
  input logic                  usr_update,
  input logic                  usr_tdi,
  input tap_state_e            tap_state,
  input logic [IR_W-1:0]       ir_q
);

  // R1
  five_tms_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> (tap_state == ST_TLR));

  // R1
  tlr_loads_bypass_chk: assert property (@(negedge tck) disable iff (!por_n)
    (tap_state == ST_TLR) |=> (ir_q == OP_BYPASS));

  // R2
  reset_follows_tlr_chk: assert property (@(posedge tck) disable iff (!por_n)
    usr_reset == (tap_state == ST_TLR));

  // R4
  sel_onehot_chk: assert property (@(negedge tck) disable iff (!por_n)
    $onehot0(usr_sel));

  // R4
  sel_change_window_chk: assert property (@(negedge tck) disable iff (!por_n)
    (usr_sel != $past(usr_sel)) |->
      ($past(tap_state) == ST_UPD_IR || $past(tap_state) == ST_TLR));

  // R5
  drck_idle_high_chk: assert property (@(posedge tck) disable iff (!por_n)
    ((~usr_sel & ~usr_drck) == '0));

  // R6
  strobes_exclusive_chk: assert property (@(negedge tck) disable iff (!por_n)
    $onehot0({usr_capture, usr_shift, usr_update}));

  // R6
  shift_strobe_chk: assert property (@(posedge tck) disable iff (!por_n)
    usr_shift == (tap_state == ST_SH_DR));

  // R11
  oe_window_chk: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (tap_state == ST_SH_DR || tap_state == ST_SH_IR));

  // R7
  always @(negedge tck) begin
    if (por_n) tdi_feed_chk: assert (usr_tdi == tdi);
  end

endmodule

bind jtag_user_tap jtag_user_tap_chk #(.NUM_CHAINS(NUM_CHAINS)) u_chk (
  .tck         (tck),
  .por_n       (por_n),
  .tms         (tms),
  .tdi         (tdi),
  .tdo_oe      (tdo_oe),
  .usr_sel     (usr_sel),
  .usr_reset   (usr_reset),
  .usr_drck    (usr_drck),
  .usr_capture (usr_capture),
  .usr_shift   (usr_shift),
  .usr_update  (usr_update),
  .usr_tdi     (usr_tdi),
  .tap_state   (tap_state),
  .ir_q        (ir_q)
);

// File: tb/jtag_user_tap_tb_top.sv
module jtag_user_tap_tb_top;

  localparam int          TCK_PERIOD = 20;
  localparam int          NCH        = 4;
  localparam logic [31:0] ID_VAL     = 32'h1A2B_C0DF;

  typedef struct {
    logic  val;
    string req;
  } exp_item_t;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, usr_reset, usr_capture, usr_shift, usr_update, usr_tdi;
  logic [NCH-1:0] usr_sel, usr_drck, usr_tdo;

  int checks = 0;
  int fails  = 0;
  int drck_cnt [NCH];
  logic [7:0] ureg [NCH];
  exp_item_t exp_q [$];

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_user_tap #(.NUM_CHAINS(NCH), .IDCODE_VAL(ID_VAL)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .usr_sel(usr_sel), .usr_reset(usr_reset), .usr_drck(usr_drck),
    .usr_capture(usr_capture), .usr_shift(usr_shift), .usr_update(usr_update),
    .usr_tdi(usr_tdi), .usr_tdo(usr_tdo)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'hA5 ^ (8'h11 * 8'(k));
  endfunction

  function automatic logic [5:0] code_of(input int k);
    logic [5:0] t [4] = '{6'h02, 6'h03, 6'h22, 6'h23};
    return t[k];
  endfunction

  function automatic logic [NCH-1:0] sel_for(input logic [5:0] op);
    logic [NCH-1:0] s = '0;
    for (int k = 0; k < NCH; k++) if (op == code_of(k)) s[k] = 1'b1;
    return s;
  endfunction

  // Byte-wide fabric register on each gated clock
  for (genvar g = 0; g < NCH; g++) begin : g_fab
    always @(posedge usr_drck[g]) begin
      drck_cnt[g] <= drck_cnt[g] + 1;
      if (usr_capture)    ureg[g] <= pat(g);
      else if (usr_shift) ureg[g] <= {usr_tdi, ureg[g][7:1]};
    end
    assign usr_tdo[g] = ureg[g][0];
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per rising edge while items are queued
  always @(posedge tck) begin
    if (exp_q.size() > 0) begin
      exp_item_t e;
      e = exp_q.pop_front();
      check(tdo === e.val && tdo_oe === 1'b1, e.req, "tdo/oe",
            {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, e.val});
    end
  end

  task automatic clk(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [5:0] op);
    exp_item_t e;
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < 6; i++) begin
      e.val = (i == 0); e.req = "R3";
      exp_q.push_back(e);
      clk(i == 5, op[i]);
    end
    clk(1, 0);
    // R4: select follows the code on this falling edge
    check(usr_sel === sel_for(op), "R4", "usr_sel after Update-IR",
          64'(usr_sel), 64'(sel_for(op)));
    clk(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din,
                          input logic [63:0] dexp, input string req);
    exp_item_t e;
    clk(1, 0);
    clk(0, 0);
    // R6: capture strobe
    check(usr_capture && !usr_shift && !usr_update, "R6", "capture strobe",
          {61'd0, usr_capture, usr_shift, usr_update}, 64'h4);
    clk(0, 0);
    // R6: shift strobe
    check(usr_shift && !usr_capture, "R6", "shift strobe",
          {61'd0, usr_capture, usr_shift, usr_update}, 64'h2);
    for (int i = 0; i < n; i++) begin
      e.val = dexp[i]; e.req = req;
      exp_q.push_back(e);
      clk(i == n - 1, din[i]);
      if (i == 0) check(usr_tdi === tdi, "R7", "usr_tdi copy", 64'(usr_tdi), 64'(tdi));
    end
    clk(1, 0);
    // R6: update strobe
    check(usr_update && !usr_shift, "R6", "update strobe",
          {61'd0, usr_capture, usr_shift, usr_update}, 64'h1);
    clk(0, 0);
    // R11: enable low outside shift states
    check(tdo_oe === 1'b0, "R11", "tdo_oe in Run-Test/Idle", 64'(tdo_oe), 64'd0);
  endtask

  task automatic clear_counts();
    for (int k = 0; k < NCH; k++) drck_cnt[k] = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d8;
    clear_counts();
    repeat (3) @(negedge tck);
    #1;
    // R1 R2 R5 R11: reset state
    check(usr_reset === 1'b1, "R2", "usr_reset under power-on", 64'(usr_reset), 64'd1);
    check(usr_sel === '0, "R4", "usr_sel under power-on", 64'(usr_sel), 64'd0);
    check(usr_drck === '1, "R5", "usr_drck idle", 64'(usr_drck), 64'hF);
    check(tdo_oe === 1'b0, "R11", "tdo_oe under power-on", 64'(tdo_oe), 64'd0);
    por_n = 1'b1;
    clk(1, 0);
    check(usr_reset === 1'b1, "R2", "usr_reset held in TLR", 64'(usr_reset), 64'd1);
    clk(0, 0);
    check(usr_reset === 1'b0, "R2", "usr_reset released", 64'(usr_reset), 64'd0);

    // R1 R9: bypass after reset
    d8 = 8'b1011_0110;
    clear_counts();
    shift_dr(8, 64'(d8), 64'({d8[6:0], 1'b0}), "R9");
    check(drck_cnt[0] == 0 && drck_cnt[3] == 0, "R5", "no drck under bypass",
          64'(drck_cnt[0] + drck_cnt[3]), 64'd0);

    // R10: identification register
    load_ir(6'h09);
    shift_dr(32, 64'd0, 64'(ID_VAL), "R10");

    // R8 R5 R7: every user chain
    for (int k = 0; k < NCH; k++) begin
      d8 = 8'h3C ^ 8'(k * 37);
      load_ir(code_of(k));
      clear_counts();
      shift_dr(8, 64'(d8), 64'(pat(k)), "R8");
      for (int j = 0; j < NCH; j++)
        check(drck_cnt[j] == ((j == k) ? 9 : 0), "R5", "drck edge count",
              64'(drck_cnt[j]), (j == k) ? 64'd9 : 64'd0);
      check(ureg[k] === d8, "R8", "fabric register after shift", 64'(ureg[k]), 64'(d8));
    end

    // R9 R4: unassigned code acts as bypass
    load_ir(6'h15);
    d8 = 8'b0110_1001;
    clear_counts();
    shift_dr(8, 64'(d8), 64'({d8[6:0], 1'b0}), "R9");
    check(drck_cnt[1] == 0, "R5", "no drck for unassigned code", 64'(drck_cnt[1]), 64'd0);

    // R1 R2: five TMS highs from inside Shift-DR with a chain selected
    load_ir(code_of(1));
    clk(1, 0); clk(0, 0); clk(0, 0);
    check(tdo_oe === 1'b1, "R11", "tdo_oe in Shift-DR", 64'(tdo_oe), 64'd1);
    repeat (5) clk(1, 0);
    check(usr_reset === 1'b1, "R2", "usr_reset after five TMS highs", 64'(usr_reset), 64'd1);
    check(usr_sel === '0, "R1", "select cleared by TLR", 64'(usr_sel), 64'd0);
    check(tdo_oe === 1'b0, "R11", "tdo_oe in TLR", 64'(tdo_oe), 64'd0);
    clk(0, 0);
    d8 = 8'hD2;
    shift_dr(8, 64'(d8), 64'({d8[6:0], 1'b0}), "R1");

    repeat (2) clk(0, 0);
    finish_run();
  end

endmodule